// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit buses, A and B, in each of a number of independent channel groups. Each transfer direction owns a storage register with its own capture clock: the A-to-B register samples what is on bus A, and the B-to-A register samples what is on bus B. An active-low enable and a direction input choose which bus the block drives, if any. A per-direction select picks what goes onto the driven bus. It is either the live value present on the opposite bus or that direction's stored register. Register capture does not depend on the enable or direction, so data can be parked in either register while both buses are isolated.

Each bus pin group is modelled with separate input, output and per-bit output-enable vectors. An input flag per bus tells the block whether some outside agent is driving that bus. A keeper register per bus remembers the last driven value and stands in for the bus when no agent drives it. Groups share nothing but the reset and the keeper sampling clock. Two 8-bit groups can therefore run separately or be wired together as one 16-bit path.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A rising edge of a group's `clk_ab` loads the value present on that group's bus A into its A-to-B register. A rising edge of `clk_ba` loads the bus B value into the B-to-A register. Both may be loaded on the same edge, and each then takes the bus value from before the edge.
- R2: Capture works for every setting of `oe_n` and `dir`. This includes isolation, and a bus the block itself is driving, in which case the driven value is stored.
- R3: While a group's `oe_n` is 1, every bit of that group's `a_oe` and `b_oe` is 0.
- R4: With `oe_n` 0 and `dir` 1, all bits of `b_oe` are 1 and `a_oe` is 0. With `oe_n` 0 and `dir` 0, all bits of `a_oe` are 1 and `b_oe` is 0.
- R5: While bus B is driven, `b_out` equals the live bus A value when `sel_ab` is 0, and the stored A-to-B register when `sel_ab` is 1.
- R6: While bus A is driven, `a_out` equals the live bus B value when `sel_ba` is 0, and the stored B-to-A register when `sel_ba` is 1.
- R7: A group never enables its A and B outputs at the same time.
- R8: Each group's outputs depend only on that group's controls, clocks and buses. Group 1's bits are [15:8] of every bus vector, and group 0's bits are [7:0].
- R9: While `rst_n` is 0, all output enables are 0, and both registers and both keepers clear to zero.
- R10: The value of a bus is the block's own output when the block drives it, otherwise `x_in` when `x_ext_drv` is 1. When neither drives it, the value is the keeper. The keeper loads the bus value on each rising `keep_clk` edge at which the bus is driven by anyone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| keep_clk | input | 1 | Sampling clock of the bus keepers |
| oe_n | input | GROUPS | Active-low output enable per group |
| dir | input | GROUPS | 1 drives bus B, 0 drives bus A |
| clk_ab | input | GROUPS | Capture clock of the A-to-B register |
| clk_ba | input | GROUPS | Capture clock of the B-to-A register |
| sel_ab | input | GROUPS | 0 live A onto B, 1 stored A onto B |
| sel_ba | input | GROUPS | 0 live B onto A, 1 stored B onto A |
| a_in | input | GROUPS*W | Value an outside agent places on bus A |
| a_ext_drv | input | GROUPS | An outside agent drives bus A |
| b_in | input | GROUPS*W | Value an outside agent places on bus B |
| b_ext_drv | input | GROUPS | An outside agent drives bus B |
| a_out | output | GROUPS*W | Value the block drives onto bus A |
| a_oe | output | GROUPS*W | Per-bit enable of `a_out` |
| b_out | output | GROUPS*W | Value the block drives onto bus B |
| b_oe | output | GROUPS*W | Per-bit enable of `b_out` |

## Verification
The hardest situation to reach is a register capture from a bus that nobody drives. The stored value must then be the keeper's memory and not the stale `a_in`. To reach it, the stimulus drives bus A from outside for a few keeper cycles, then withdraws the driver and changes `a_in`, and only then pulses the capture clock. The result is read back through the stored transfer path. A second hard case is a capture of the bus the block is driving from the other register while both clocks fire together. The sweep covers this by pulsing both clocks in every control combination and predicting each register from the bus values before the edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which source feeds the driven bus
  typedef enum logic {
    XF_LIVE   = 1'b0,
    XF_STORED = 1'b1
  } xfer_src_e;

  // Which bus of a group the block owns
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } bus_owner_e;

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 8
) (
  input  logic         keep_clk,
  input  logic         rst_n,
  input  logic         driven,
  input  logic [W-1:0] pin,
  output logic [W-1:0] held
);

  always_ff @(posedge keep_clk or negedge rst_n) begin
    if (!rst_n)      held <= '0;
    else if (driven) held <= pin;
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 8
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic [W-1:0] cap_data,
  input  logic [W-1:0] live_data,
  input  logic         sel,
  output logic [W-1:0] out_data
);
  import xcvr_pkg::*;

  logic [W-1:0] stored_q;
  logic         use_stored;

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) stored_q <= '0;
    else        stored_q <= cap_data;
  end

  assign use_stored = (sel == XF_STORED);

  // AND-OR selection: each bit comes from exactly one source
  assign out_data = ({W{use_stored}} & stored_q) | ({W{~use_stored}} & live_data);

endmodule

// File: rtl/xcvr_group.sv
module xcvr_group #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         keep_clk,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic         a_ext_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_ext_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  import xcvr_pkg::*;

  bus_owner_e   owner;
  logic         drive_a, drive_b;
  logic [W-1:0] a_keep, b_keep;
  logic [W-1:0] a_view, b_view;
  logic [W-1:0] a_pin, b_pin;
  logic [W-1:0] to_a, to_b;

  always_comb begin
    owner = OWN_NONE;
    if (rst_n && !oe_n) owner = dir ? OWN_B : OWN_A;
  end

  assign drive_a = (owner == OWN_A);
  assign drive_b = (owner == OWN_B);

  // Bus value seen without the block's own drive
  assign a_view = a_ext_drv ? a_in : a_keep;
  assign b_view = b_ext_drv ? b_in : b_keep;

  // Resolved pin values, block drive wins
  assign a_pin = drive_a ? to_a : a_view;
  assign b_pin = drive_b ? to_b : b_view;

  xcvr_path #(.W(W)) u_ab (
    .cap_clk  (clk_ab),
    .rst_n    (rst_n),
    .cap_data (a_pin),
    .live_data(a_view),
    .sel      (sel_ab),
    .out_data (to_b)
  );

  xcvr_path #(.W(W)) u_ba (
    .cap_clk  (clk_ba),
    .rst_n    (rst_n),
    .cap_data (b_pin),
    .live_data(b_view),
    .sel      (sel_ba),
    .out_data (to_a)
  );

  xcvr_keeper #(.W(W)) u_keep_a (
    .keep_clk(keep_clk),
    .rst_n   (rst_n),
    .driven  (drive_a | a_ext_drv),
    .pin     (a_pin),
    .held    (a_keep)
  );

  xcvr_keeper #(.W(W)) u_keep_b (
    .keep_clk(keep_clk),
    .rst_n   (rst_n),
    .driven  (drive_b | b_ext_drv),
    .pin     (b_pin),
    .held    (b_keep)
  );

  assign a_out = to_a;
  assign b_out = to_b;
  assign a_oe  = {W{drive_a}};
  assign b_oe  = {W{drive_b}};

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int W      = 8,
  parameter int GROUPS = 2
) (
  input  logic                  rst_n,
  input  logic                  keep_clk,
  input  logic [GROUPS-1:0]     oe_n,
  input  logic [GROUPS-1:0]     dir,
  input  logic [GROUPS-1:0]     clk_ab,
  input  logic [GROUPS-1:0]     clk_ba,
  input  logic [GROUPS-1:0]     sel_ab,
  input  logic [GROUPS-1:0]     sel_ba,
  input  logic [GROUPS*W-1:0]   a_in,
  input  logic [GROUPS-1:0]     a_ext_drv,
  input  logic [GROUPS*W-1:0]   b_in,
  input  logic [GROUPS-1:0]     b_ext_drv,
  output logic [GROUPS*W-1:0]   a_out,
  output logic [GROUPS*W-1:0]   a_oe,
  output logic [GROUPS*W-1:0]   b_out,
  output logic [GROUPS*W-1:0]   b_oe
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    xcvr_group #(.W(W)) u_grp (
      .rst_n    (rst_n),
      .keep_clk (keep_clk),
      .oe_n     (oe_n[g]),
      .dir      (dir[g]),
      .clk_ab   (clk_ab[g]),
      .clk_ba   (clk_ba[g]),
      .sel_ab   (sel_ab[g]),
      .sel_ba   (sel_ba[g]),
      .a_in     (a_in[g*W +: W]),
      .a_ext_drv(a_ext_drv[g]),
      .b_in     (b_in[g*W +: W]),
      .b_ext_drv(b_ext_drv[g]),
      .a_out    (a_out[g*W +: W]),
      .a_oe     (a_oe[g*W +: W]),
      .b_out    (b_out[g*W +: W]),
      .b_oe     (b_oe[g*W +: W])
    );
  end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W      = 8,
  parameter int GROUPS = 2
) (
  input logic                  rst_n,
  input logic                  keep_clk,
  input logic [GROUPS-1:0]     oe_n,
  input logic [GROUPS-1:0]     dir,
  input logic [GROUPS-1:0]     sel_ab,
  input logic [GROUPS-1:0]     sel_ba,
  input logic [GROUPS*W-1:0]   a_in,
  input logic [GROUPS-1:0]     a_ext_drv,
  input logic [GROUPS*W-1:0]   b_in,
  input logic [GROUPS-1:0]     b_ext_drv,
  input logic [GROUPS*W-1:0]   a_out,
  input logic [GROUPS*W-1:0]   a_oe,
  input logic [GROUPS*W-1:0]   b_out,
  input logic [GROUPS*W-1:0]   b_oe
);

  always_comb begin
    if (rst_n == 1'b0) begin
      assert_reset_quiet_R9: assert (a_oe == '0 && b_oe == '0)
        else $error("outputs enabled during reset");
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    assert_isolate_R3: assert property (@(posedge keep_clk) disable iff (!rst_n)
      oe_n[g] |-> (a_oe[g*W +: W] == '0 && b_oe[g*W +: W] == '0));

    assert_drive_b_R4: assert property (@(posedge keep_clk) disable iff (!rst_n)
      (!oe_n[g] && dir[g]) |-> (&b_oe[g*W +: W]));

    assert_drive_a_R4: assert property (@(posedge keep_clk) disable iff (!rst_n)
      (!oe_n[g] && !dir[g]) |-> (&a_oe[g*W +: W]));

    assert_one_bus_R7: assert property (@(posedge keep_clk) disable iff (!rst_n)
      !((|a_oe[g*W +: W]) && (|b_oe[g*W +: W])));

    assert_live_ab_R5: assert property (@(posedge keep_clk) disable iff (!rst_n)
      (!oe_n[g] && dir[g] && !sel_ab[g] && a_ext_drv[g]) |-> (b_out[g*W +: W] == a_in[g*W +: W]));

    assert_live_ba_R6: assert property (@(posedge keep_clk) disable iff (!rst_n)
      (!oe_n[g] && !dir[g] && !sel_ba[g] && b_ext_drv[g]) |-> (a_out[g*W +: W] == b_in[g*W +: W]));
  end

endmodule

bind reg_bus_xcvr xcvr_checker #(.W(W), .GROUPS(GROUPS)) u_chk (
  .rst_n    (rst_n),
  .keep_clk (keep_clk),
  .oe_n     (oe_n),
  .dir      (dir),
  .sel_ab   (sel_ab),
  .sel_ba   (sel_ba),
  .a_in     (a_in),
  .a_ext_drv(a_ext_drv),
  .b_in     (b_in),
  .b_ext_drv(b_ext_drv),
  .a_out    (a_out),
  .a_oe     (a_oe),
  .b_out    (b_out),
  .b_oe     (b_oe)
);

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;

  logic        rst_n = 1'b0;
  logic        clk = 1'b0;
  logic [1:0]  oe_n = 2'b11, dir = 2'b00, clk_ab = 2'b00, clk_ba = 2'b00;
  logic [1:0]  sel_ab = 2'b00, sel_ba = 2'b00, a_ext_drv = 2'b00, b_ext_drv = 2'b00;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, a_oe, b_out, b_oe;

  int tests = 0;
  int fails = 0;

  // Group 0 reference state
  logic [7:0] ma, mb, ka, kb;

  always #5 clk = ~clk;

  reg_bus_xcvr #(.W(8), .GROUPS(2)) uut (
    .rst_n(rst_n), .keep_clk(clk), .oe_n(oe_n), .dir(dir),
    .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_ext_drv(a_ext_drv), .b_in(b_in), .b_ext_drv(b_ext_drv),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] view_a();
    return a_ext_drv[0] ? a_in[7:0] : ka;
  endfunction
  function automatic logic [7:0] view_b();
    return b_ext_drv[0] ? b_in[7:0] : kb;
  endfunction
  function automatic logic [7:0] pin_a();
    if (!oe_n[0] && !dir[0]) return sel_ba[0] ? mb : view_b();
    return view_a();
  endfunction
  function automatic logic [7:0] pin_b();
    if (!oe_n[0] && dir[0]) return sel_ab[0] ? ma : view_a();
    return view_b();
  endfunction

  // One step on group 0: apply controls, optional captures, check outputs
  task automatic step0(input logic o, input logic d, input logic sab, input logic sba,
                       input logic [7:0] av, input logic [7:0] bv,
                       input logic ae, input logic be, input logic pa, input logic pb);
    logic [7:0] na, nb, exp_out;
    @(negedge clk);
    oe_n[0] = o; dir[0] = d; sel_ab[0] = sab; sel_ba[0] = sba;
    a_in[7:0] = av; b_in[7:0] = bv; a_ext_drv[0] = ae; b_ext_drv[0] = be;
    #1;
    na = pin_a(); nb = pin_b();
    clk_ab[0] = pa; clk_ba[0] = pb;
    #1;
    if (pa) ma = na;   // R1: value from before the edge
    if (pb) mb = nb;
    clk_ab[0] = 1'b0; clk_ba[0] = 1'b0;
    #1;
    chk(o ? "R3 a_oe" : "R4 a_oe", {8'h0, a_oe[7:0]}, {8'h0, (!o && !d) ? 8'hFF : 8'h00});
    chk(o ? "R3 b_oe" : "R4 b_oe", {8'h0, b_oe[7:0]}, {8'h0, (!o && d) ? 8'hFF : 8'h00});
    if (!o && d) begin
      exp_out = sab ? ma : view_a();
      chk(sab ? "R5 stored, R1 R2 capture" : "R5 live", {8'h0, b_out[7:0]}, {8'h0, exp_out});
    end
    if (!o && !d) begin
      exp_out = sba ? mb : view_b();
      chk(sba ? "R6 stored, R1 R2 capture" : "R6 live", {8'h0, a_out[7:0]}, {8'h0, exp_out});
    end
    chk("R8 group 1 untouched", {b_oe[15:8], b_out[15:8]}, {8'hFF, 8'h5A});
    @(posedge clk);
    #1;
    // R10 keeper follows any driven bus
    if ((!o && !d) || ae) ka = pin_a();
    if ((!o && d) || be) kb = pin_b();
  endtask

  initial begin
    #3_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ma = '0; mb = '0; ka = '0; kb = '0;
    oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
    #22;
    chk("R9 a_oe in reset", a_oe, 16'h0);
    chk("R9 b_oe in reset", b_oe, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R9 cleared register", b_out, 16'h0);

    // Group 1: keeper test, R10
    @(negedge clk);
    oe_n[1] = 1'b1; a_ext_drv[1] = 1'b1; a_in[15:8] = 8'h5A;
    repeat (2) @(negedge clk);
    a_ext_drv[1] = 1'b0; a_in[15:8] = 8'hFF;
    repeat (2) @(negedge clk);
    clk_ab[1] = 1'b1; #1 clk_ab[1] = 1'b0;
    #1 oe_n[1] = 1'b0; dir[1] = 1'b1; sel_ab[1] = 1'b0;
    #1 chk("R10 live from keeper", {8'h0, b_out[15:8]}, 16'h005A);
    sel_ab[1] = 1'b1;
    #1 chk("R10 captured keeper", {8'h0, b_out[15:8]}, 16'h005A);

    // Group 0 near-exhaustive sweep
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 2; p++) begin
          step0(c[0], c[1], c[2], c[3],
                8'(c * 37 + k * 11 + p * 5 + 3), 8'(c * 53 + k * 7 + p * 29 + 8'h90),
                (k != 3), (k != 2), k[0] | p[0], k[1] | p[0]);
        end
      end
    end

    // Simultaneous storage in isolation, read both back (R1 R2)
    step0(1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);
    step0(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 stored A after isolation", {8'h0, b_out[7:0]}, 16'h00C3);
    step0(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 stored B after isolation", {8'h0, a_out[7:0]}, 16'h003C);
    chk("R7 one bus only", {15'h0, (|a_oe[7:0]) & (|b_oe[7:0])}, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule